// File: doc/BRIEF.md
# Valid-Qualified Triple-Lane Majority Voter

This block sits between three redundant data producers and a single output bus. When a triplet is presented, it compares the three words, each with its own valid flag, and forwards the word that at least two valid lanes agree on. A lane can only count towards the majority if it is marked valid. It therefore never wins by carrying the right value while flagged invalid.

The comparison is purely combinational. The triplet is accepted on the voter clock when the strobe is high, and the outcome is registered once. Four things come out of that register: the voted word, an output-valid pulse, one error flag per lane, and a no-majority flag. An error-correction controller downstream reads the flags to decide which lane needs recovery. That controller, error counting and recovery are outside this block.

Top module: `tmr_voter`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are zero on the following cycle: `voted_word`, `voted_valid`, `lane_err` and `no_majority`.
- R2: If all three lanes are valid and carry equal words, the next cycle shows `voted_word` equal to that word, `voted_valid`=1, `lane_err`=3'b000 and `no_majority`=0.
- R3: If exactly two valid lanes agree and the third valid lane differs, the output is the agreed word with `voted_valid`=1. Only the bit of the differing lane is set in `lane_err`, where bit k belongs to lane k.
- R4: A lane whose `lane_ok` bit is 0 sets its `lane_err` bit and is never counted, even when its word matches another lane. If the remaining valid lanes do not agree, the result is no majority.
- R5: A triplet with no majority gives `voted_valid`=0, `no_majority`=1 and `lane_err`=3'b111, while `voted_word` keeps its previous value. No majority means that no two valid lanes carry equal words.
- R6: The result of a triplet accepted with `trip_strobe`=1 appears exactly one cycle after the accepting edge, and only for that one cycle. This holds for back-to-back triplets too.
- R7: A cycle without `trip_strobe` gives `voted_valid`=0, `no_majority`=0 and `lane_err`=0 on the next cycle, and `voted_word` stays unchanged whatever the lane inputs carry.
- R8: Whenever `voted_valid` is 1, at most one `lane_err` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Voter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_strobe | input | 1 | A triplet is presented this cycle |
| lane0_word | input | DATA_W | Word from lane 0 |
| lane1_word | input | DATA_W | Word from lane 1 |
| lane2_word | input | DATA_W | Word from lane 2 |
| lane_ok | input | 3 | Valid flag per lane (bit k = lane k) |
| voted_word | output | DATA_W | Majority word, held between wins |
| voted_valid | output | 1 | Pulse: `voted_word` holds a fresh majority |
| lane_err | output | 3 | Per-lane disagreement or invalid flag |
| no_majority | output | 1 | Pulse: the last triplet had no majority |

## Verification
Two decisions can land on the same lane within a single triplet: invalid-lane exclusion and word matching. This happens when a lane is flagged invalid yet carries the word that would otherwise form or join the majority. The sweep provokes this by running every valid mask against every combination of a four-value word alphabet, so invalid lanes often carry matching words. It judges the outcome by whether the result falls back to no majority or to the remaining valid pair, and by the lane's error bit. The strobe pattern interleaves back-to-back triplets with idle cycles that carry garbage words, which also confirms that the held output word is left untouched.

// File: rtl/tmr_voter_pkg.sv
// Package: shared constants and types for the triple-lane voter.
// Assumes exactly three lanes; pair p compares lanes (lo(p), hi(p)).
package tmr_voter_pkg;
    localparam int NUM_LANES = 3;
    localparam int NUM_PAIRS = 3;

    // Flags produced by one vote, before registering.
    typedef struct packed {
        logic [NUM_LANES-1:0] err;
        logic                 none;
        logic                 win;
    } vote_flags_t;

    // Lower lane index of comparison pair p: 0,0,1
    function automatic int pair_lo(input int p);
        return (p == 2) ? 1 : 0;
    endfunction

    // Upper lane index of comparison pair p: 1,2,2
    function automatic int pair_hi(input int p);
        return (p == 0) ? 1 : 2;
    endfunction
endpackage

// File: rtl/vote_pair_cmp.sv
// Module: compares two lanes; agreement needs both valid and equal words.
// Assumes nothing about timing: purely combinational.
module vote_pair_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] word_b,
    input  logic              ok_a,
    input  logic              ok_b,
    output logic              agree
);
    // Purpose: qualified equality of the two lanes
    always_comb begin
        agree = ok_a && ok_b && (word_a == word_b);
    end
endmodule

// File: rtl/vote_select.sv
// Module: from the three pair agreements, picks the winning word and
// derives per-lane error flags. A lane is healthy only if it agrees
// with at least one other lane; with no agreement every lane is flagged.
// Assumes agree[p] already includes both lanes' valid flags.
module vote_select
    import tmr_voter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]    word0,
    input  logic [DATA_W-1:0]    word1,
    input  logic [NUM_PAIRS-1:0] agree,   // [0]=0/1 [1]=0/2 [2]=1/2
    output logic [DATA_W-1:0]    win_word,
    output vote_flags_t          flags
);
    logic lane0_in_pair;
    logic lane1_in_pair;
    logic lane2_in_pair;

    // Purpose: membership of each lane in some agreeing pair
    always_comb begin
        lane0_in_pair = agree[0] || agree[1];
        lane1_in_pair = agree[0] || agree[2];
        lane2_in_pair = agree[1] || agree[2];
    end

    // Purpose: winner mux and flag derivation
    always_comb begin
        win_word   = lane0_in_pair ? word0 : word1;
        flags.win  = |agree;
        flags.none = ~(|agree);
        flags.err  = {~lane2_in_pair, ~lane1_in_pair, ~lane0_in_pair};
    end
endmodule

// File: rtl/vote_out_stage.sv
// Module: registers the vote result when a triplet is accepted.
// Flags and the valid pulse last one cycle; the word is held until the
// next winning triplet. Synchronous active-low reset clears everything.
module vote_out_stage
    import tmr_voter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [DATA_W-1:0]    win_word,
    input  vote_flags_t          flags,
    output logic [DATA_W-1:0]    out_word,
    output logic                 out_valid,
    output logic [NUM_LANES-1:0] out_err,
    output logic                 out_none
);
    // Purpose: pulse-style flag register, cleared on idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= '0;
            out_none  <= 1'b0;
        end else if (accept) begin
            out_valid <= flags.win;
            out_err   <= flags.err;
            out_none  <= flags.none;
        end else begin
            out_valid <= 1'b0;
            out_err   <= '0;
            out_none  <= 1'b0;
        end
    end

    // Purpose: hold register for the voted word, loaded only on a win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
        end else if (accept && flags.win) begin
            out_word <= win_word;
        end
    end

    // R6
    valid_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(accept));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!out_valid && !out_none && out_err == '0));

    // R5
    none_all_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_none |-> (out_err == '1 && !out_valid));

    // R8
    single_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_err) <= 1));

    // R7
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(out_word));
endmodule

// File: rtl/tmr_voter.sv
// Module: top of the valid-qualified majority voter. Compares three
// lanes pairwise, selects the majority and registers the outcome.
// Assumes the synchronizer holds a triplet stable in the strobe cycle.
module tmr_voter
    import tmr_voter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trip_strobe,
    input  logic [DATA_W-1:0]    lane0_word,
    input  logic [DATA_W-1:0]    lane1_word,
    input  logic [DATA_W-1:0]    lane2_word,
    input  logic [NUM_LANES-1:0] lane_ok,
    output logic [DATA_W-1:0]    voted_word,
    output logic                 voted_valid,
    output logic [NUM_LANES-1:0] lane_err,
    output logic                 no_majority
);
    logic [DATA_W-1:0]    lane_w [NUM_LANES];
    logic [NUM_PAIRS-1:0] pair_agree;
    logic [DATA_W-1:0]    win_word;
    vote_flags_t          flags;

    // Purpose: gather lane words into an indexable array
    always_comb begin
        lane_w[0] = lane0_word;
        lane_w[1] = lane1_word;
        lane_w[2] = lane2_word;
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int LO = pair_lo(p);
        localparam int HI = pair_hi(p);
        vote_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
            .word_a (lane_w[LO]),
            .word_b (lane_w[HI]),
            .ok_a   (lane_ok[LO]),
            .ok_b   (lane_ok[HI]),
            .agree  (pair_agree[p])
        );
    end

    vote_select #(.DATA_W(DATA_W)) u_sel (
        .word0    (lane0_word),
        .word1    (lane1_word),
        .agree    (pair_agree),
        .win_word (win_word),
        .flags    (flags)
    );

    vote_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (trip_strobe),
        .win_word  (win_word),
        .flags     (flags),
        .out_word  (voted_word),
        .out_valid (voted_valid),
        .out_err   (lane_err),
        .out_none  (no_majority)
    );

    // R4
    invalid_lane_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_strobe |=> ((lane_err | $past(lane_ok)) == 3'b111));
endmodule

// File: tb/sim_tmr_voter.sv
`timescale 1ns/1ps
module sim_tmr_voter;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trip_strobe = 1'b0;
    logic [DW-1:0] w0 = '0, w1 = '0, w2 = '0;
    logic [2:0]    ok = '0;
    logic [DW-1:0] voted_word;
    logic          voted_valid;
    logic [2:0]    lane_err;
    logic          no_majority;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // pending expectation for the next sampling point
    bit            pend = 0;
    bit            e_valid, e_none;
    logic [2:0]    e_err;
    logic [DW-1:0] e_word = '0;
    string         e_tag;

    always #10 clk = ~clk;

    tmr_voter #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .trip_strobe(trip_strobe),
        .lane0_word(w0), .lane1_word(w1), .lane2_word(w2), .lane_ok(ok),
        .voted_word(voted_word), .voted_valid(voted_valid),
        .lane_err(lane_err), .no_majority(no_majority)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            chk({e_tag, " valid"}, 32'(voted_valid), 32'(e_valid));
            chk({e_tag, " none"},  32'(no_majority), 32'(e_none));
            chk({e_tag, " err"},   32'(lane_err),    32'(e_err));
            chk({e_tag, " word"},  32'(voted_word),  32'(e_word));
        end
    endtask

    // Apply one cycle of stimulus; model the expected result arithmetically.
    task automatic drive(input bit stb, input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [DW-1:0] c, input logic [2:0] m);
        logic [DW-1:0] d [3];
        bit in_pair [3];
        int partners;
        @(negedge clk);
        check_pending();
        trip_strobe = stb; w0 = a; w1 = b; w2 = c; ok = m;
        d[0] = a; d[1] = b; d[2] = c;
        for (int k = 0; k < 3; k++) begin
            partners = 0;
            for (int j = 0; j < 3; j++)
                if (j != k && m[j] && m[k] && d[j] == d[k]) partners++;
            in_pair[k] = (partners > 0);
        end
        if (!stb) begin
            e_valid = 0; e_none = 0; e_err = 3'b000;
            e_tag = "R7 idle";
        end else begin
            e_err = {~in_pair[2], ~in_pair[1], ~in_pair[0]};
            e_valid = in_pair[0] | in_pair[1] | in_pair[2];
            e_none = ~e_valid;
            if (e_valid) begin
                for (int k = 2; k >= 0; k--) if (in_pair[k]) e_word = d[k];
            end
            if (e_none)                 e_tag = "R5/R4 no-majority";
            else if (e_err == 3'b000)   e_tag = "R2 unanimous";
            else if (m != 3'b111)       e_tag = "R4 invalid-lane";
            else                        e_tag = "R3/R8 two-of-three";
        end
        pend = 1;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 32'(voted_valid), 0);
        chk("R1 reset none",  32'(no_majority), 0);
        chk("R1 reset err",   32'(lane_err),    0);
        chk("R1 reset word",  32'(voted_word),  0);
        rst_n = 1'b1;
        // R6: single-cycle pulse after a unanimous triplet, then idle
        drive(1, 8'h3C, 8'h3C, 8'h3C, 3'b111);
        drive(0, 8'h3C, 8'h3C, 8'h3C, 3'b111);
        drive(0, 8'h11, 8'h22, 8'h33, 3'b000);
        // Exhaustive sweep: 4-value alphabet per lane x all valid masks
        for (int i = 0; i < 512; i++) begin
            drive(1, DW'(i[4:3]), DW'(i[6:5]), DW'(i[8:7]), i[2:0]);
            if (i % 3 == 1) drive(0, 8'hA5, 8'h5A, 8'hA5, 3'b101);
        end
        // Wide-value cases outside the alphabet
        drive(1, 8'hFF, 8'h80, 8'hFF, 3'b111);
        drive(1, 8'h01, 8'h01, 8'h02, 3'b100);
        drive(0, 8'h00, 8'h00, 8'h00, 3'b111);
        @(negedge clk);
        check_pending();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule